// File: doc/BRIEF.md
# Secondary Interrupt Source Controller

This block collects a parameterised bank of interrupt sources and reports them to two independent host masters. It first synchronises every source input into the block clock. A per-source edge selector then decides whether a rising edge, a falling edge, both or neither is an event. Each event is latched into a status bit. Each of the two active-low interrupt outputs has its own status vector and its own mask vector. The edge selector is common to both outputs.

A small synchronous byte-wide register port gives the host access to the block. Each master can read its status and acknowledge it, either by reading it or by writing ones to it. It can also mask sources and force status bits to test its interrupt path. A control register chooses the acknowledge style, enables a second-event buffer per status bit, and selects an exclusive routing mode in which an event appears on only one output.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1, every status bit and buffered event is 0, the edge-select bytes read 0, the control register reads 0, and both `irq_n` outputs are high.
- R2: Source i has a 2-bit edge field at edge-select bits 2i+1 (rising enable) and 2i (falling enable), which is byte i/4 at bit offset 2*(i%4). A rising input change sets the status bit when the upper bit is 1. A falling change sets it when the lower bit is 1. The status bit is visible no later than four clock cycles after the input changes.
- R3: A source whose edge field is 00 never sets a status bit on either output, whatever its input does.
- R4: A mask bit of 1 stops that source from driving that output. `irq_n[k]` is low exactly when output k has a status bit set whose mask bit is 0. Outside exclusive mode, an event sets the status bit on both outputs.
- R5: With control bit 0 (clear-on-read) set, a host read of a status byte returns the current bits and clears the bits it returned. Writes to a status byte are ignored.
- R6: With control bit 0 clear, writing 1 to a status bit clears it, writing 0 leaves it unchanged, and reads do not clear.
- R7: With control bit 2 (buffering) set, an event on a status bit that is already set is stored in a secondary latch. The next clear sets the status bit again from that latch and empties the latch, so a second acknowledge is needed to fully drain the bit.
- R8: With control bit 1 (exclusive) set, an event goes only to output 0 when output 0's mask bit for that source is 0, and only to output 1 otherwise.
- R9: Writing 1 to a bit of an output's force register sets that output's status bit. The force register reads as 0.
- R10: If an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R11: Byte addresses for N=8: control 0, edge-select 1..2, output 0 status/mask/force 3/4/5, output 1 status/mask/force 6/7/8. In general, status and mask take ceil(N/8) bytes and edge-select takes ceil(2N/8) bytes. Multi-byte registers are little-endian, with the lowest source in bit 0 of the lowest address. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | N | Asynchronous interrupt source inputs |
| addr | input | AW | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq_n | output | 2 | Active-low interrupt, one per host master |

## Verification
The bench targets the cycle in which an edge arriving from the synchroniser meets a host clear of the same bit. If the design let the clear win, an event would be lost and the status would read 0. A second event with buffering on must refill the status after the first acknowledge. A design that drops the buffer drains in one read, and one that never empties the buffer never drains. Exclusive routing is tested by toggling output 0's mask between events. A wrong steering rule shows up as the event on both outputs or on the wrong one. Edge fields of 00 and fields that enable only the opposite edge are toggled to catch a wrong bit pairing or a wrong packing offset.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int NUM_LINES = 2;
   // control register bit positions
   localparam int CTRL_COR_BIT  = 0;
   localparam int CTRL_EXCL_BIT = 1;
   localparam int CTRL_BUF_BIT  = 2;
   localparam int CTRL_W        = 3;

   function automatic int bytes_for(input int bits);
      return (bits + 7) / 8;
   endfunction
endpackage

// File: rtl/sirq_edge_det.sv
module sirq_edge_det #(
   parameter int N           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   src_in,
   input  logic [2*N-1:0] edge_sel,
   output logic [N-1:0]   hit
);
   logic [N-1:0] sync_q [SYNC_STAGES];
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
         prev_q <= '0;
      end else begin
         sync_q[0] <= src_in;
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic now_s;
      assign now_s  = sync_q[SYNC_STAGES-1][i];
      assign hit[i] = (edge_sel[2*i+1] &  now_s & ~prev_q[i])
                    | (edge_sel[2*i]   & ~now_s &  prev_q[i]);
   end
endmodule

// File: rtl/sirq_line_bank.sv
module sirq_line_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         buf_en,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] frc,
   input  logic [N-1:0] mask_we,
   input  logic [N-1:0] mask_wd,
   output logic [N-1:0] stat,
   output logic [N-1:0] pend,
   output logic [N-1:0] mask
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat[i] <= 1'b0;
            pend[i] <= 1'b0;
            mask[i] <= 1'b1;
         end else begin
            if (mask_we[i]) mask[i] <= mask_wd[i];
            if (clr[i]) begin
               // new event wins over the clear; buffered event refills
               stat[i] <= hit[i] | frc[i] | pend[i];
               pend[i] <= pend[i] & hit[i];
            end else begin
               stat[i] <= stat[i] | hit[i] | frc[i];
               pend[i] <= pend[i] | (buf_en & stat[i] & hit[i]);
            end
         end
      end
   end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
   import sirq_pkg::*;
#(
   parameter int N           = 8,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  src_in,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic [7:0]    rdata,
   output logic [1:0]    irq_n
);
   localparam int NB        = bytes_for(N);
   localparam int NE        = bytes_for(2*N);
   localparam int A_CTRL    = 0;
   localparam int A_EDGE    = 1;
   localparam int A_LINE0   = A_EDGE + NE;
   localparam int LINE_SPAN = 3*NB;
   localparam int NREG      = A_LINE0 + NUM_LINES*LINE_SPAN;

   if (N < 1 || N > 32) begin : g_bad_n
      $error("sirq_ctrl: N must be 1..32");
   end
   if (NREG > (1 << AW)) begin : g_bad_aw
      $error("sirq_ctrl: AW too small for register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sirq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [2*N-1:0]    edge_q;
   logic [N-1:0]      hit;
   logic              cor, excl, buf_en;

   logic [NUM_LINES-1:0][N-1:0] stat_v, pend_v, mask_v, hit_v;
   logic [NUM_LINES-1:0][N-1:0] clr_v, frc_v, mwe_v;

   assign cor    = ctrl_q[CTRL_COR_BIT];
   assign excl   = ctrl_q[CTRL_EXCL_BIT];
   assign buf_en = ctrl_q[CTRL_BUF_BIT];

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (wr_en && addr == AW'(A_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
   end

   // shared edge-select bits, byte-addressed, little-endian
   for (genvar p = 0; p < 2*N; p++) begin : g_edge
      localparam logic [AW-1:0] EA = AW'(A_EDGE + p/8);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) edge_q[p] <= 1'b0;
         else if (wr_en && addr == EA) edge_q[p] <= wdata[p%8];
      end
   end

   sirq_edge_det #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .edge_sel(edge_q), .hit(hit)
   );

   // exclusive mode steers each event to one output
   assign hit_v[0] = hit & (~{N{excl}} | ~mask_v[0]);
   assign hit_v[1] = hit & (~{N{excl}} |  mask_v[0]);

   for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
      for (genvar i = 0; i < N; i++) begin : g_dec
         localparam logic [AW-1:0] SA = AW'(A_LINE0 + k*LINE_SPAN + i/8);
         localparam logic [AW-1:0] MA = AW'(A_LINE0 + k*LINE_SPAN + NB + i/8);
         localparam logic [AW-1:0] FA = AW'(A_LINE0 + k*LINE_SPAN + 2*NB + i/8);
         assign clr_v[k][i] = (addr == SA) &
                              ((wr_en & ~cor & wdata[i%8]) | (rd_en & cor));
         assign frc_v[k][i] = wr_en & (addr == FA) & wdata[i%8];
         assign mwe_v[k][i] = wr_en & (addr == MA);
      end

      sirq_line_bank #(.N(N)) u_bank (
         .clk(clk), .rst_n(rst_n), .buf_en(buf_en),
         .hit(hit_v[k]), .clr(clr_v[k]), .frc(frc_v[k]),
         .mask_we(mwe_v[k]), .mask_wd({(N+7)/8{wdata}}[N-1:0]),
         .stat(stat_v[k]), .pend(pend_v[k]), .mask(mask_v[k])
      );

      assign irq_n[k] = ~|(stat_v[k] & ~mask_v[k]);
   end

   // read mux
   logic [8*NE-1:0] edge_pad;
   logic [8*NB-1:0] stat_pad [NUM_LINES];
   logic [8*NB-1:0] mask_pad [NUM_LINES];
   logic [7:0]      rd_byte;

   always_comb begin
      edge_pad = '0;
      edge_pad[2*N-1:0] = edge_q;
      for (int k = 0; k < NUM_LINES; k++) begin
         stat_pad[k] = '0;
         stat_pad[k][N-1:0] = stat_v[k];
         mask_pad[k] = '0;
         mask_pad[k][N-1:0] = mask_v[k];
      end
      rd_byte = '0;
      if (addr == AW'(A_CTRL)) rd_byte[CTRL_W-1:0] = ctrl_q;
      for (int b = 0; b < NE; b++)
         if (addr == AW'(A_EDGE + b)) rd_byte = edge_pad[8*b +: 8];
      for (int k = 0; k < NUM_LINES; k++)
         for (int b = 0; b < NB; b++) begin
            if (addr == AW'(A_LINE0 + k*LINE_SPAN + b))
               rd_byte = stat_pad[k][8*b +: 8];
            if (addr == AW'(A_LINE0 + k*LINE_SPAN + NB + b))
               rd_byte = mask_pad[k][8*b +: 8];
         end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else if (rd_en) rdata <= rd_byte;
   end
endmodule

// File: rtl/sirq_ctrl_chk.sv
module sirq_ctrl_chk #(
   parameter int N = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic           rd_en,
   input logic [1:0]     irq_n,
   input logic           excl,
   input logic [2*N-1:0] edge_sel,
   input logic [N-1:0]   stat0,
   input logic [N-1:0]   pend0,
   input logic [N-1:0]   clr0,
   input logic [N-1:0]   hit0,
   input logic [N-1:0]   hit1
);
   logic [N-1:0] sel_any;
   for (genvar i = 0; i < N; i++) begin : g_sel
      assign sel_any[i] = edge_sel[2*i+1] | edge_sel[2*i];
   end

   assert_release_on_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_n[0]) || $rose(irq_n[1])) |-> $past(wr_en || rd_en));

   assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(stat0) & ~stat0) & ~$past(clr0)) == '0));

   assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr0 & hit0) & ~stat0) == '0));

   assert_buffer_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr0 & pend0) & ~stat0) == '0));

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      excl |-> ((hit0 & hit1) == '0));

   assert_sel_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit0 | hit1) & ~sel_any) == '0);
endmodule

bind sirq_ctrl sirq_ctrl_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .irq_n(irq_n),
   .excl(excl), .edge_sel(edge_q), .stat0(stat_v[0]), .pend0(pend_v[0]),
   .clr0(clr_v[0]), .hit0(hit_v[0]), .hit1(hit_v[1])
);

// File: tb/sirq_ctrl_tb_top.sv
module sirq_ctrl_tb_top;
   localparam int N = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_in = '0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [7:0]    rdata;
   logic [1:0]    irq_n;

   sirq_ctrl #(.N(N), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq_n(irq_n)
   );

   always #2 clk = ~clk;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 0;

   logic [7:0]  m_stat [2];
   logic [7:0]  m_pend [2];
   logic [7:0]  m_mask [2];
   logic [15:0] m_edge;
   logic [2:0]  m_ctrl;
   logic [7:0]  m_src;

   function automatic int sa(int k); return 3 + 3*k; endfunction

   task automatic check(string req, int unsigned act, int unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [7:0] d);
      @(negedge clk); addr = AW'(a); wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(int a, output logic [7:0] d);
      @(negedge clk); addr = AW'(a); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   function automatic logic [1:0] exp_irq();
      return {~|(m_stat[1] & ~m_mask[1]), ~|(m_stat[0] & ~m_mask[0])};
   endfunction

   task automatic chk_irq(string req);
      check(req, irq_n, exp_irq());
   endtask

   task automatic set_ctrl(logic [2:0] c); wr(0, {5'b0, c}); m_ctrl = c; endtask
   task automatic set_edge(logic [15:0] e);
      wr(1, e[7:0]); wr(2, e[15:8]); m_edge = e;
   endtask
   task automatic set_mask(int k, logic [7:0] d); wr(sa(k)+1, d); m_mask[k] = d; endtask
   task automatic force_st(int k, logic [7:0] d); wr(sa(k)+2, d); m_stat[k] |= d; endtask

   task automatic model_event(int k, int i);
      if (m_stat[k][i] && m_ctrl[2]) m_pend[k][i] = 1'b1;
      m_stat[k][i] = 1'b1;
   endtask

   task automatic model_hit(int i, logic v);
      if ((v && m_edge[2*i+1]) || (!v && m_edge[2*i])) begin
         if (m_ctrl[1]) model_event(m_mask[0][i] ? 1 : 0, i);
         else begin model_event(0, i); model_event(1, i); end
      end
   endtask

   task automatic toggle(int i);
      logic v;
      v = ~m_src[i];
      @(negedge clk); src_in[i] = v;
      repeat (4) @(negedge clk);
      m_src[i] = v;
      model_hit(i, v);
   endtask

   task automatic model_clear(int k, logic [7:0] bits);
      for (int i = 0; i < 8; i++)
         if (bits[i]) begin m_stat[k][i] = m_pend[k][i]; m_pend[k][i] = 1'b0; end
   endtask

   task automatic rd_stat(int k, string req);
      logic [7:0] d;
      rd(sa(k), d);
      check(req, d, m_stat[k]);
      if (m_ctrl[0]) model_clear(k, d);
   endtask

   task automatic w1c(int k, logic [7:0] d);
      wr(sa(k), d);
      if (!m_ctrl[0]) model_clear(k, d);
   endtask

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240611));
      m_stat = '{8'h0, 8'h0}; m_pend = '{8'h0, 8'h0}; m_mask = '{8'hFF, 8'hFF};
      m_edge = '0; m_ctrl = '0; m_src = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq_n", irq_n, 2'b11);
      rd(0, d);  check("R1 ctrl", d, 8'h00);
      rd(1, d);  check("R1 edge byte0", d, 8'h00);
      rd(2, d);  check("R1 edge byte1", d, 8'h00);
      rd(4, d);  check("R1 mask0", d, 8'hFF);
      rd(7, d);  check("R1 mask1", d, 8'hFF);
      rd_stat(0, "R1 stat0"); rd_stat(1, "R1 stat1");

      // R3 edge field 00 never sets
      toggle(0); toggle(0); toggle(3);
      rd_stat(0, "R3 stat0 sel off"); rd_stat(1, "R3 stat1 sel off");

      // R2/R11 packing: src0 rising (bit 1), src5 falling (bit 10)
      set_edge(16'h0402);
      rd(1, d); check("R11 edge low byte", d, 8'h02);
      rd(2, d); check("R11 edge high byte", d, 8'h04);
      toggle(0);
      rd_stat(0, "R2 rise sets src0");
      toggle(5);
      rd_stat(1, "R2 rise ignored on falling-only src5");
      toggle(5);
      rd_stat(0, "R2 fall sets src5");
      rd_stat(0, "R6 read does not clear");
      chk_irq("R4 all masked");
      set_mask(0, 8'hFE);
      chk_irq("R4 unmasked src0 line0 only");
      w1c(0, 8'h01);
      rd_stat(0, "R6 write one clears");
      chk_irq("R4 released after clear");

      // R5 clear-on-read
      set_ctrl(3'b001);
      w1c(1, 8'h21);
      rd_stat(1, "R5 write ignored, read returns");
      rd_stat(1, "R5 read cleared");

      // R7 buffering with clear-on-read
      set_ctrl(3'b101);
      rd_stat(0, "R7 flush line0");
      set_edge(16'h0003);
      toggle(0); toggle(0);
      rd_stat(0, "R7 first read");
      rd_stat(0, "R7 refilled from buffer");
      rd_stat(0, "R7 drained");
      rd_stat(1, "R7 line1 first");
      rd_stat(1, "R7 line1 refill");

      // R8 exclusive routing
      set_ctrl(3'b011);
      rd_stat(1, "R8 flush line1");
      set_mask(0, 8'hFE);
      toggle(0);
      rd_stat(1, "R8 line1 untouched");
      rd_stat(0, "R8 line0 got event");
      set_mask(0, 8'hFF);
      toggle(0);
      rd_stat(0, "R8 line0 untouched when masked");
      rd_stat(1, "R8 line1 got event");

      // R9 force
      set_ctrl(3'b000);
      set_mask(1, 8'h7F);
      force_st(1, 8'h80);
      chk_irq("R9 forced irq line1");
      rd(sa(1)+2, d); check("R9 force reads zero", d, 8'h00);
      rd_stat(1, "R9 forced status");
      w1c(1, 8'h80);
      chk_irq("R9 cleared");

      // R10 edge and clear in the same cycle
      set_edge(16'h0030);
      toggle(2);
      rd_stat(0, "R10 pre-set src2");
      @(negedge clk); src_in[2] = 1'b0;
      @(negedge clk);
      @(negedge clk); addr = AW'(sa(0)); wdata = 8'h04; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      repeat (3) @(negedge clk);
      m_src[2] = 1'b0;
      model_hit(2, 1'b0);
      rd_stat(0, "R10 edge wins over clear");

      // constrained random mix
      set_edge(16'($urandom));
      for (int it = 0; it < 80; it++) begin
         int op;
         int k;
         op = int'($urandom_range(0, 6));
         k  = int'($urandom_range(0, 1));
         case (op)
            0, 1: toggle(int'($urandom_range(0, N-1)));
            2: rd_stat(k, "R5/R6 random read");
            3: w1c(k, 8'($urandom));
            4: set_mask(k, 8'($urandom));
            5: force_st(k, 8'(1 << $urandom_range(0, 7)));
            default: set_ctrl(3'($urandom));
         endcase
         chk_irq("R4 random irq");
      end
      rd_stat(0, "R4 final line0"); rd_stat(1, "R4 final line1");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule